// File: doc/BRIEF.md
# External Bus Cycle Controller

This block turns read, write and code-fetch requests from inside the chip into timed cycles on an external parallel bus. The bus data path is either 8 or 16 bits wide, chosen by a configuration input. For every cycle the controller drives the address, an active-low chip select, output enable, write strobe, and two byte-lane strobes. Two configuration inputs set, in clocks, how long the address sits on the bus before the strobes fall and how long the strobes stay low. A WAIT input from the slow device can stretch the strobe phase one clock at a time.

A requester hands over one request at a time with a valid/ready pair. The request carries an operation code, a byte address, write data, a two-bit byte mask and a fetch length in bytes. On an 8-bit bus, a full-word read or write becomes two byte cycles: the even byte goes first and the odd byte second. Code fetches always run as bursts. The chip select stays low from the first beat to the last, and the low address bits step on every beat. Each fetched word or byte, and each completed read, comes back as a one-clock pulse on the response port.

Top module: `ebus_ctrl`

## Requirements
- R1: While reset is held, and after it is released, the chip select, output enable, write strobe and both lane strobes are high. The data-drive enable and the response pulse are low, and ready is high.
- R2: Every beat has three phases. First comes an address phase of cfg_setup+1 clocks, with chip select low and all strobes high. Next comes a strobe phase of cfg_strobe+1 clocks. Last comes a single hold clock with the strobes high, chip select low and the address unchanged. Ready is high only while no cycle is in progress.
- R3: The controller samples bus_wait only at the rising edge that ends the final strobe clock, and then at the edge that ends each extension clock. Each high sample adds one strobe clock. A high bus_wait during the address phase, the earlier strobe clocks or the hold clock has no effect.
- R4: Read data on bus_din is captured at the edge that ends the last active strobe clock. It is presented on rsp_data with rsp_valid high for exactly the following (hold) clock.
- R5: On a 16-bit bus, a read or write drives the lanes from the mask. Mask bit 0 selects the low lane (the even byte), and bit 1 selects the high lane (the odd byte). Mask 00 counts as 11. bus_addr[0] is 1 only for mask 10.
- R6: On an 8-bit bus, the low lane strobe falls during every strobe phase, for any address. The high lane strobe never falls.
- R7: On an 8-bit bus, a read or write with mask 11 (or 00) runs as two byte cycles. The first is at the even address and the second at the odd address. A read returns one response after the second byte, as {odd, even}. A single-byte read returns its byte in its own lane position, with the other byte zero.
- R8: Operation codes 1x are fetches. The length is clamped to 2..16 bytes. A 16-bit bus runs ceil(len/2) word beats with bus_addr[0]=0, bus_addr[3:1] counting up modulo 8 and both lanes active. An 8-bit bus runs len byte beats with bus_addr[3:0] counting up modulo 16. Higher address bits never change. Chip select stays low across all beats. Each beat returns one response (on an 8-bit bus, {8'h00, byte}).
- R9: Output enable falls only for reads (op 00) and fetches. The write strobe falls only for writes (op 01). bus_doe is high only for writes, from the address phase through the hold clock, so it is never high while output enable is low.
- R10: On a 16-bit bus, bus_dout carries req_wdata. On an 8-bit bus it carries {8'h00, byte}, where the byte is req_wdata[7:0] for an even bus address and req_wdata[15:8] for an odd one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bus16 | input | 1 | 1 selects a 16-bit data bus, 0 an 8-bit bus |
| cfg_setup | input | CW | Address phase length minus one, in clocks |
| cfg_strobe | input | CW | Strobe phase length minus one, in clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_op | input | 2 | 00 read, 01 write, 1x fetch |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte mask for reads and writes |
| req_blen | input | LW | Fetch length in bytes |
| rsp_valid | output | 1 | One-clock pulse with returned data |
| rsp_data | output | 16 | Returned data |
| bus_addr | output | AW | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_ble_n | output | 1 | Low byte-lane strobe, active low |
| bus_bhe_n | output | 1 | High byte-lane strobe, active low |
| bus_dout | output | 16 | Write data toward the pads |
| bus_doe | output | 1 | Enable for the data drivers |
| bus_din | input | 16 | Data from the pads |
| bus_wait | input | 1 | Cycle stretch request |

## Verification
Two events can fall in the same clock edge: the strobe counter running out, and a WAIT sample that decides whether data is captured. The bench holds bus_wait high through the address phase, through every strobe clock and through the hold clock, and drops it only on the clock that should end the beat. It also changes bus_din on every strobe clock. A design that samples WAIT too early or too late, or that captures on the wrong edge, therefore shows both a wrong strobe length and a wrong response value. Both are compared against a behavioural per-clock model. A second overlap is the hold clock of one burst beat and the address step for the next. Chip select must stay low across that boundary while the address moves.

// File: rtl/ebus_pkg.sv
// Package: shared types and limits for the external bus cycle controller.
// Assumes: byte addressing, data bus of at most 16 bits.
package ebus_pkg;
    localparam int MIN_BURST = 2;
    localparam int MAX_BURST = 16;
    localparam int WRAP_BITS = $clog2(MAX_BURST);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STROBE,
        ST_WAITX,
        ST_HOLD
    } ebus_state_e;

    typedef enum logic [1:0] {
        OP_READ      = 2'b00,
        OP_WRITE     = 2'b01,
        OP_FETCH     = 2'b10,
        OP_FETCH_ALT = 2'b11
    } ebus_op_e;
endpackage

// File: rtl/ebus_req_decode.sv
// Module: ebus_req_decode
// Purpose: purely combinational; from a request and the bus width it derives
// the first bus address, the number of beats and the active byte lanes.
// Assumes: op[1] marks a fetch; the mask is ignored for fetches.
module ebus_req_decode
    import ebus_pkg::*;
#(
    parameter int AW = 20,
    parameter int LW = 5
) (
    input  logic          bus16,
    input  ebus_op_e      op,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    mask,
    input  logic [LW-1:0] blen,
    output logic [AW-1:0] start_addr,
    output logic [LW-1:0] nbeats,
    output logic [1:0]    lanes
);
    localparam logic [LW-1:0] BL_MIN = LW'(MIN_BURST);
    localparam logic [LW-1:0] BL_MAX = LW'(MAX_BURST);
    localparam logic [LW-1:0] ONE    = LW'(1);
    localparam logic [LW-1:0] TWO    = LW'(2);

    logic [1:0]    m_eff;
    logic [LW-1:0] bl_eff;

    // Map the request to its beat plan.
    always_comb begin
        m_eff = (mask == 2'b00) ? 2'b11 : mask;
        if (blen < BL_MIN)      bl_eff = BL_MIN;
        else if (blen > BL_MAX) bl_eff = BL_MAX;
        else                    bl_eff = blen;

        start_addr = addr;
        nbeats     = ONE;
        lanes      = 2'b01;
        if (op == OP_FETCH || op == OP_FETCH_ALT) begin
            if (bus16) begin
                start_addr[0] = 1'b0;
                nbeats        = (bl_eff + ONE) >> 1;
                lanes         = 2'b11;
            end else begin
                nbeats = bl_eff;
            end
        end else if (bus16) begin
            start_addr[0] = (m_eff == 2'b10);
            lanes         = m_eff;
        end else if (m_eff == 2'b11) begin
            start_addr[0] = 1'b0;
            nbeats        = TWO;
        end else begin
            start_addr[0] = (m_eff == 2'b10);
        end
    end
endmodule

// File: rtl/ebus_addr_step.sv
// Module: ebus_addr_step
// Purpose: next beat address; steps the word index on a 16-bit bus or the
// byte index on an 8-bit bus, wrapping inside an aligned burst block.
// Assumes: AW > WRAP; upper address bits never change within a request.
module ebus_addr_step #(
    parameter int AW   = 20,
    parameter int WRAP = 4
) (
    input  logic          bus16,
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);
    localparam logic [WRAP-2:0] W_ONE = (WRAP-1)'(1);
    localparam logic [WRAP-1:0] B_ONE = WRAP'(1);

    // Increment only the low index bits selected by the bus width.
    always_comb begin
        nxt = cur;
        if (bus16) nxt[WRAP-1:1] = cur[WRAP-1:1] + W_ONE;
        else       nxt[WRAP-1:0] = cur[WRAP-1:0] + B_ONE;
    end
endmodule

// File: rtl/ebus_phase_seq.sv
// Module: ebus_phase_seq
// Purpose: phase sequencer of one bus beat: address setup, strobe, WAIT
// extension, hold; chains to the next beat or returns to idle.
// Assumes: cfg values stay stable while a request is in progress.
module ebus_phase_seq
    import ebus_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_strobe,
    input  logic          bus_wait,
    input  logic          more_beats,
    output ebus_state_e   state,
    output logic          capture
);
    logic [CW-1:0] cnt;

    // Capture happens on the edge that ends the final active strobe clock.
    always_comb begin
        capture = ((state == ST_STROBE) && (cnt == '0) && !bus_wait) ||
                  ((state == ST_WAITX) && !bus_wait);
    end

    // Phase state and clock counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_ADDR;
                    cnt   <= cfg_setup;
                end
                ST_ADDR: if (cnt == '0) begin
                    state <= ST_STROBE;
                    cnt   <= cfg_strobe;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                ST_STROBE: if (cnt == '0) begin
                    state <= bus_wait ? ST_WAITX : ST_HOLD;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                ST_WAITX: if (!bus_wait) state <= ST_HOLD;
                ST_HOLD: if (more_beats) begin
                    state <= ST_ADDR;
                    cnt   <= cfg_setup;
                end else begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: an extension clock only follows a high WAIT sample.
    a_r3_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAITX) |-> $past(bus_wait));
endmodule

// File: rtl/ebus_ctrl.sv
// Module: ebus_ctrl (top)
// Purpose: accepts one request at a time, plans its beats, runs them
// through the phase sequencer and drives the external bus pins and the
// response port.
// Assumes: configuration is stable while busy; the requester holds its
// request fields only in the accepting clock.
module ebus_ctrl
    import ebus_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 4,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_bus16,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_strobe,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    input  logic [1:0]    req_bmask,
    input  logic [LW-1:0] req_blen,
    output logic          rsp_valid,
    output logic [15:0]   rsp_data,
    output logic [AW-1:0] bus_addr,
    output logic          bus_cs_n,
    output logic          bus_oe_n,
    output logic          bus_we_n,
    output logic          bus_ble_n,
    output logic          bus_bhe_n,
    output logic [15:0]   bus_dout,
    output logic          bus_doe,
    input  logic [15:0]   bus_din,
    input  logic          bus_wait
);
    localparam logic [LW-1:0] ONE = LW'(1);

    ebus_state_e   state;
    logic          capture;
    logic          accept;
    logic          more_beats;
    logic          active;
    logic [AW-1:0] dec_addr;
    logic [AW-1:0] nxt_addr;
    logic [LW-1:0] dec_beats;
    logic [1:0]    dec_lanes;

    logic          bus16_q;
    logic          wr_q;
    logic          fe_q;
    logic [1:0]    lanes_q;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] left_q;
    logic [15:0]   wdata_q;
    logic [7:0]    acc_lo_q;
    logic [7:0]    acc_hi_q;

    ebus_req_decode #(.AW(AW), .LW(LW)) u_dec (
        .bus16      (cfg_bus16),
        .op         (ebus_op_e'(req_op)),
        .addr       (req_addr),
        .mask       (req_bmask),
        .blen       (req_blen),
        .start_addr (dec_addr),
        .nbeats     (dec_beats),
        .lanes      (dec_lanes)
    );

    ebus_addr_step #(.AW(AW), .WRAP(WRAP_BITS)) u_step (
        .bus16 (bus16_q),
        .cur   (addr_q),
        .nxt   (nxt_addr)
    );

    ebus_phase_seq #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .cfg_setup  (cfg_setup),
        .cfg_strobe (cfg_strobe),
        .bus_wait   (bus_wait),
        .more_beats (more_beats),
        .state      (state),
        .capture    (capture)
    );

    // Handshake and phase decode.
    always_comb begin
        req_ready  = (state == ST_IDLE);
        accept     = req_valid && req_ready;
        more_beats = (left_q > ONE);
        active     = (state == ST_STROBE) || (state == ST_WAITX);
    end

    // Pin drive from the latched request and the current phase.
    always_comb begin
        bus_addr  = addr_q;
        bus_cs_n  = (state == ST_IDLE);
        bus_oe_n  = !(active && !wr_q);
        bus_we_n  = !(active && wr_q);
        bus_ble_n = !(active && lanes_q[0]);
        bus_bhe_n = !(active && lanes_q[1]);
        bus_doe   = wr_q && (state != ST_IDLE);
        if (bus16_q) bus_dout = wdata_q;
        else         bus_dout = {8'h00, addr_q[0] ? wdata_q[15:8] : wdata_q[7:0]};
    end

    // Request latch and beat advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus16_q <= 1'b0;
            wr_q    <= 1'b0;
            fe_q    <= 1'b0;
            lanes_q <= 2'b00;
            addr_q  <= '0;
            left_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            bus16_q <= cfg_bus16;
            wr_q    <= (req_op == OP_WRITE);
            fe_q    <= req_op[1];
            lanes_q <= dec_lanes;
            addr_q  <= dec_addr;
            left_q  <= dec_beats;
            wdata_q <= req_wdata;
        end else if (state == ST_HOLD && more_beats) begin
            addr_q <= nxt_addr;
            left_q <= left_q - ONE;
        end
    end

    // Read data capture, byte assembly and the response pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            acc_lo_q  <= '0;
            acc_hi_q  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                acc_lo_q <= '0;
                acc_hi_q <= '0;
            end else if (capture && !wr_q) begin
                if (fe_q) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= bus16_q ? bus_din : {8'h00, bus_din[7:0]};
                end else if (bus16_q) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= bus_din;
                end else begin
                    if (addr_q[0]) acc_hi_q <= bus_din[7:0];
                    else           acc_lo_q <= bus_din[7:0];
                    if (!more_beats) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= addr_q[0] ? {bus_din[7:0], acc_lo_q}
                                               : {acc_hi_q, bus_din[7:0]};
                    end
                end
            end
        end
    end

    // R9: drivers stay off whenever the slave may drive the bus.
    a_r9_no_drive_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> !bus_doe);
    // R6: high lane never used on a narrow bus.
    a_r6_no_high_lane: assert property (@(posedge clk) disable iff (!rst_n)
        !bus16_q |-> bus_bhe_n);
    // R2: address is held through the hold clock.
    a_r2_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> $stable(bus_addr));
    // R2: no acceptance while a cycle owns the bus.
    a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> bus_cs_n);
    // R8: chip select bridges beats of a burst.
    a_r8_cs_bridge: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && more_beats) |=> !bus_cs_n);
    // R4: responses are single-clock pulses.
    a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: tb/ebus_ctrl_tb.sv
module ebus_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int CW = 4;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_bus16 = 1'b1;
    logic [CW-1:0] cfg_setup = '0;
    logic [CW-1:0] cfg_strobe = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_bmask = '0;
    logic [LW-1:0] req_blen = '0;
    logic          rsp_valid;
    logic [15:0]   rsp_data;
    logic [AW-1:0] bus_addr;
    logic          bus_cs_n, bus_oe_n, bus_we_n, bus_ble_n, bus_bhe_n, bus_doe;
    logic [15:0]   bus_dout;
    logic [15:0]   bus_din = '0;
    logic          bus_wait = 1'b0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    ebus_ctrl #(.AW(AW), .CW(CW), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_bus16(cfg_bus16), .cfg_setup(cfg_setup),
        .cfg_strobe(cfg_strobe), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_bmask(req_bmask), .req_blen(req_blen), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
        .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_ble_n(bus_ble_n),
        .bus_bhe_n(bus_bhe_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_wait(bus_wait)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog R2 actual=%0d expected<=100000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [7:0] ctl();
        return {bus_cs_n, bus_oe_n, bus_we_n, bus_ble_n, bus_bhe_n, bus_doe, rsp_valid, req_ready};
    endfunction

    function automatic logic [15:0] dinval(int b, int k);
        return 16'(32'h3C00 + b * 32'h0111 + k * 32'h1203);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural per-clock model of one request, compared every clock.
    task automatic run(input logic [1:0] op, input logic [AW-1:0] addr, input logic [15:0] wd,
                       input logic [1:0] mask, input int blen, input bit b16,
                       input int setup, input int strb, input int wt, input string tag);
        int nb, bl, w;
        logic [1:0] m, ln;
        logic [AW-1:0] a;
        logic [15:0] acc, dv, expd, expo;
        bit wr, fe, rv;
        logic [7:0] e;
        wr = (op == 2'b01);
        fe = op[1];
        m = (mask == 2'b00) ? 2'b11 : mask;
        bl = (blen < 2) ? 2 : ((blen > 16) ? 16 : blen);
        if (fe) nb = b16 ? (bl + 1) / 2 : bl;
        else    nb = (!b16 && m == 2'b11) ? 2 : 1;
        acc = '0;
        @(negedge clk);
        cfg_bus16 = b16; cfg_setup = CW'(setup); cfg_strobe = CW'(strb);
        chk(ctl() == 8'hF9, "R2 idle before request", 32'(ctl()), 32'hF9);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
        req_bmask = mask; req_blen = LW'(blen);
        @(negedge clk);
        req_valid = 1'b0; req_wdata = 16'hDEAD;
        for (int b = 0; b < nb; b++) begin
            if (fe && b16)      a = {addr[AW-1:4], 3'(addr[3:1] + 3'(b)), 1'b0};
            else if (fe)        a = {addr[AW-1:4], 4'(addr[3:0] + 4'(b))};
            else if (b16)       a = {addr[AW-1:1], m == 2'b10};
            else if (m == 2'b11) a = {addr[AW-1:1], b[0]};
            else                a = {addr[AW-1:1], m == 2'b10};
            ln = b16 ? (fe ? 2'b11 : m) : 2'b01;
            w = (b % 2 == 0) ? wt : 0;
            expo = b16 ? wd : {8'h00, a[0] ? wd[15:8] : wd[7:0]};
            for (int k = 0; k <= setup; k++) begin
                bus_wait = 1'b1; bus_din = 16'hFFFF;
                e = {1'b0, 4'b1111, wr, 1'b0, 1'b0};
                chk(ctl() == e, {tag, " R2 R9 address phase"}, 32'(ctl()), 32'(e));
                chk(bus_addr == a, {tag, " address"}, 32'(bus_addr), 32'(a));
                if (wr) chk(bus_dout == expo, "R10 write data", 32'(bus_dout), 32'(expo));
                @(negedge clk);
            end
            for (int k = 0; k <= strb + w; k++) begin
                bus_wait = (k < strb + w);
                bus_din = dinval(b, k);
                e = {1'b0, wr, !wr, !ln[0], !ln[1], wr, 1'b0, 1'b0};
                chk(ctl() == e, {tag, (w > 0) ? " R3" : "", " R2 R9 strobe phase"}, 32'(ctl()), 32'(e));
                chk(bus_addr == a, {tag, " address"}, 32'(bus_addr), 32'(a));
                if (wr) chk(bus_dout == expo, "R10 write data", 32'(bus_dout), 32'(expo));
                @(negedge clk);
            end
            dv = dinval(b, strb + w);
            rv = 1'b0; expd = '0;
            if (fe) begin
                rv = 1'b1; expd = b16 ? dv : {8'h00, dv[7:0]};
            end else if (!wr) begin
                if (b16) begin
                    rv = 1'b1; expd = dv;
                end else begin
                    if (a[0]) acc[15:8] = dv[7:0]; else acc[7:0] = dv[7:0];
                    rv = (b == nb - 1); expd = acc;
                end
            end
            bus_wait = 1'b1; bus_din = 16'hFFFF;
            e = {1'b0, 4'b1111, wr, rv, 1'b0};
            chk(ctl() == e, {tag, " R2 R3 R4 hold"}, 32'(ctl()), 32'(e));
            chk(bus_addr == a, {tag, " R2 hold address"}, 32'(bus_addr), 32'(a));
            if (rv) chk(rsp_data == expd, {tag, " R4 response data"}, 32'(rsp_data), 32'(expd));
            @(negedge clk);
        end
        bus_wait = 1'b0;
        chk(ctl() == 8'hF9, "R2 idle after request", 32'(ctl()), 32'hF9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ctl() == 8'hF9, "R1 reset outputs", 32'(ctl()), 32'hF9);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctl() == 8'hF9, "R1 after reset release", 32'(ctl()), 32'hF9);
        // 16-bit bus reads and writes
        run(2'b00, 20'h01230, 16'h0000, 2'b11, 0, 1'b1, 0, 0, 0, "R5 rd16");
        run(2'b01, 20'h01232, 16'hA1B2, 2'b01, 0, 1'b1, 1, 2, 0, "R5 wr16 even");
        run(2'b01, 20'h01235, 16'hC3D4, 2'b10, 0, 1'b1, 0, 1, 2, "R5 wr16 odd");
        run(2'b00, 20'h04440, 16'h0000, 2'b00, 0, 1'b1, 2, 0, 3, "R5 rd16 mask00");
        // 8-bit bus: split and single byte
        run(2'b01, 20'h05550, 16'h5A6B, 2'b11, 0, 1'b0, 2, 1, 1, "R7 R6 wr8 split");
        run(2'b00, 20'h05552, 16'h0000, 2'b11, 0, 1'b0, 0, 2, 2, "R7 R6 rd8 split");
        run(2'b00, 20'h05553, 16'h0000, 2'b10, 0, 1'b0, 1, 0, 0, "R7 R6 rd8 high byte");
        run(2'b01, 20'h05557, 16'h789A, 2'b10, 0, 1'b0, 0, 0, 1, "R7 R6 wr8 odd byte");
        // Fetch bursts with wrap and length clamp
        run(2'b10, 20'h12346, 16'h0000, 2'b00, 16, 1'b1, 0, 1, 1, "R8 fetch16 len16");
        run(2'b11, 20'h2345D, 16'h0000, 2'b00, 5, 1'b0, 1, 0, 2, "R8 R6 fetch8 len5");
        run(2'b10, 20'h3333A, 16'h0000, 2'b00, 0, 1'b1, 0, 0, 0, "R8 fetch len0 clamp");
        run(2'b10, 20'h44449, 16'h0000, 2'b00, 31, 1'b0, 0, 0, 0, "R8 fetch8 len31 clamp");
        run(2'b10, 20'h5555C, 16'h0000, 2'b00, 3, 1'b1, 1, 1, 1, "R8 fetch16 len3");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule